// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block watches a wide bus of general-purpose input pins and drives eight interrupt request lines toward a system interrupt controller. Each of the eight channels is programmed with three things: which pin it listens to, whether it reports a level or an edge, and whether that sense is inverted. An optional glitch filter per channel makes the selected pin hold a new value for a programmable number of clocks before the channel accepts it.

Software programs the block through four 32-bit words behind a word-indexed read/write port. All pins pass through a two-stage synchronizer before selection. A channel whose selector is 0xff, or names a pin that does not exist, is disconnected and stays quiet. A channel in edge mode catches only one direction. To catch both edges of one pin, software points two channels at it, one inverted and one not.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every `irq_out` bit is 0. Reading word 0 returns 0x00000000, words 1 and 2 return 0xFFFFFFFF and word 3 returns 0x00000000. `reg_rdata` shows the word named by `reg_addr` one clock after that address is presented.
- R2: A write with `reg_wr_en` high stores `reg_wdata` into the word at `reg_addr` (0 = mode, 1 = selectors of channels 0-3, 2 = selectors of channels 4-7, 3 = filter). Reads return the stored value. In word 3 only bits [4k+2:4k] are kept, so the unused bits read 0.
- R3: Channel k takes its pin number from bits [8*(k mod 4)+7 : 8*(k mod 4)] of word 1 for k < 4 and of word 2 for k >= 4.
- R4: In word 0, bit k = 0 selects level mode for channel k and bit 16+k = 1 inverts it. In level mode with no filter, `irq_out[k]` equals the selected pin (XOR the invert bit), three clocks after the pin changes.
- R5: With bit k of word 0 set (edge mode), channel k emits a one-clock pulse when the synchronized pin rises. If bit 16+k is also set, it pulses when the pin falls instead. It never pulses on both edges.
- R6: Two edge-mode channels that select the same pin, one inverted and one not, together report every rising and every falling edge of that pin, one pulse each.
- R7: A selector value of 0xFF, or any value at or above the pin count (64 by default), holds that channel's output at 0 whatever the pins do.
- R8: A nonzero 3-bit filter value N in word 3 bits [4k+2:4k] makes channel k accept a new pin value only after the value has differed from the accepted one for 4*N consecutive clocks. A shorter glitch is ignored. N = 0 bypasses the filter.
- R9: Changing a channel's selector, mode, polarity or filter value produces no edge pulse. The channel's history reloads from the newly selected input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | NUM_PINS | Asynchronous pin inputs |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the word addressed in the previous clock |
| irq_out | output | 8 | Registered interrupt request per channel |

## Verification
The hardest case to reach is a configuration change that lands while the new source is already at its active level. A careless design would report a false edge there. The stimulus parks two pins at opposite levels and arms an edge channel on the low one. It then re-points the selector to the high pin, and in a second step flips the channel from level to edge mode while the pin is high, and counts the pulses. Filter timing is also hard to reach. Glitches one clock shorter than the window are driven, then held values whose acceptance is sampled on the exact clock. A long random phase then rewrites selectors, polarity and filter values under toggling pins, against a behavioural model.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int NUM_CH   = 8;
  localparam int SRC_W    = 8;
  localparam int FLT_W    = 3;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int SEL_PER_WORD = REG_W / SRC_W;
  localparam int FLT_STRIDE   = REG_W / NUM_CH;
  localparam int INV_BASE     = 16;

  typedef enum logic [ADDR_W-1:0] {
    W_MODE   = 2'd0,
    W_SEL_LO = 2'd1,
    W_SEL_HI = 2'd2,
    W_FILT   = 2'd3
  } word_e;

  localparam logic [REG_W-1:0] FILT_MASK = 32'h7777_7777;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic             edge_md;
    logic             inv;
    logic [FLT_W-1:0] flt;
  } chan_cfg_t;

  localparam chan_cfg_t CFG_RST = '{src: 8'hff, edge_md: 1'b0, inv: 1'b0, flt: 3'd0};
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  mode_q,
  output logic [REG_W-1:0]  sel_lo_q,
  output logic [REG_W-1:0]  sel_hi_q,
  output logic [REG_W-1:0]  filt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      sel_lo_q <= '1;
      sel_hi_q <= '1;
      filt_q   <= '0;
      rdata    <= '0;
    end else begin
      // read sees the value held before a same-cycle write
      case (word_e'(addr))
        W_MODE:   rdata <= mode_q;
        W_SEL_LO: rdata <= sel_lo_q;
        W_SEL_HI: rdata <= sel_hi_q;
        default:  rdata <= filt_q;
      endcase
      if (wr_en) begin
        case (word_e'(addr))
          W_MODE:   mode_q   <= wdata;
          W_SEL_LO: sel_lo_q <= wdata;
          W_SEL_HI: sel_hi_q <= wdata;
          default:  filt_q   <= wdata & FILT_MASK;
        endcase
      end
    end
  end
endmodule

// File: rtl/gir_chan.sv
module gir_chan
  import gir_pkg::*;
#(
  parameter int NUM_PINS  = 64,
  parameter int FILT_UNIT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins,
  input  chan_cfg_t           cfg,
  output logic                irq
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int CNT_W = $clog2(((1 << FLT_W) - 1) * FILT_UNIT + 1);

  chan_cfg_t        cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             acc_q;   // filtered, accepted level
  logic             hist_q;  // edge history

  logic con, raw, pc, lvl, chg, win_done, no_flt;

  always_comb begin
    con      = ({1'b0, cfg.src} < (SRC_W + 1)'(NUM_PINS));
    raw      = con ? pins[cfg.src[IDX_W-1:0]] : 1'b0;
    pc       = con & (raw ^ cfg.inv);
    no_flt   = (cfg.flt == '0);
    lvl      = no_flt ? pc : acc_q;
    chg      = (cfg != cfg_q);
    win_done = (int'(cnt_q) == int'(cfg.flt) * FILT_UNIT - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RST;
      cnt_q  <= '0;
      acc_q  <= 1'b0;
      hist_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      cfg_q <= cfg;
      if (chg || no_flt) begin
        acc_q <= pc;
        cnt_q <= '0;
      end else if (pc == acc_q) begin
        cnt_q <= '0;
      end else if (win_done) begin
        acc_q <= pc;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      hist_q <= chg ? pc : lvl;
      irq    <= con & (cfg.edge_md ? (~chg & lvl & ~hist_q) : lvl);
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int NUM_PINS  = 64,
  parameter int FILT_UNIT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] gpio_in,
  input  logic                reg_wr_en,
  input  logic [1:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic [7:0]          irq_out
);
  logic [NUM_PINS-1:0] pins_s;
  logic [REG_W-1:0]    mode_w, sel_lo, sel_hi, filt_w;
  logic [REG_W-1:0]    sel_words [NUM_CH / SEL_PER_WORD];

  gir_sync #(.W(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (gpio_in),
    .q   (pins_s)
  );

  gir_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .mode_q   (mode_w),
    .sel_lo_q (sel_lo),
    .sel_hi_q (sel_hi),
    .filt_q   (filt_w)
  );

  assign sel_words[0] = sel_lo;
  assign sel_words[1] = sel_hi;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    chan_cfg_t cfg;
    assign cfg.src     = sel_words[k / SEL_PER_WORD][SRC_W*(k % SEL_PER_WORD) +: SRC_W];
    assign cfg.edge_md = mode_w[k];
    assign cfg.inv     = mode_w[INV_BASE + k];
    assign cfg.flt     = filt_w[FLT_STRIDE*k +: FLT_W];

    gir_chan #(.NUM_PINS(NUM_PINS), .FILT_UNIT(FILT_UNIT)) u_chan (
      .clk  (clk),
      .rst  (rst),
      .pins (pins_s),
      .cfg  (cfg),
      .irq  (irq_out[k])
    );
  end
endmodule

// File: rtl/gir_checker.sv
module gir_checker
  import gir_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  irq_out,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic [31:0] mode_w,
  input logic [31:0] sel_lo,
  input logic [31:0] sel_hi
);
  logic [7:0] off;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      off[k]     = ({1'b0, sel_lo[8*k +: 8]} >= 9'(NUM_PINS));
      off[k + 4] = ({1'b0, sel_hi[8*k +: 8]} >= 9'(NUM_PINS));
    end
  end

  // R1: outputs come out of reset quiet
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (irq_out == 8'h00));

  // R2: spare filter bits never read back as one
  a_r2_filter_spare_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == 2'd3) |-> ((reg_rdata & ~FILT_MASK) == 32'h0));

  // R5: an edge-mode channel never holds its request for two clocks
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & $past(irq_out) & $past(mode_w[7:0])) == 8'h00));

  // R7: a disconnected channel stays silent
  a_r7_disconnected_silent: assert property (@(posedge clk) disable iff (rst)
    ((irq_out & $past(off)) == 8'h00));
endmodule

bind gpio_irq_router gir_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_out   (irq_out),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .mode_w    (mode_w),
  .sel_lo    (sel_lo),
  .sel_hi    (sel_hi)
);

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] gpio = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [31:0]   wdata = '0;
  wire  [31:0]   rdata;
  wire  [7:0]    irq;

  always #4 clk = ~clk;

  gpio_irq_router #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rst(rst), .gpio_in(gpio), .reg_wr_en(wr_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
  );

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string req = "R1";

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // behavioural reference, advanced once per rising edge
  logic [NP-1:0] m_s1, m_s2;
  logic [31:0]   m_reg [4];
  logic [31:0]   m_rd;
  logic [7:0]    m_irq;
  logic [12:0]   m_pcfg [8];
  int            m_cnt [8];
  bit            m_acc [8], m_hist [8];

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_rd = '0; m_irq = '0;
      m_reg[0] = 32'h0; m_reg[1] = '1; m_reg[2] = '1; m_reg[3] = 32'h0;
      for (int k = 0; k < 8; k++) begin
        m_pcfg[k] = {8'hff, 5'b0}; m_cnt[k] = 0; m_acc[k] = 0; m_hist[k] = 0;
      end
    end else begin
      logic [7:0] nirq;
      for (int k = 0; k < 8; k++) begin
        logic [7:0] s; bit e, v, c, p, l, ch; int n; logic [12:0] cf;
        s  = (k < 4) ? m_reg[1][8*k +: 8] : m_reg[2][8*(k-4) +: 8];
        e  = m_reg[0][k];
        v  = m_reg[0][16+k];
        n  = int'(m_reg[3][4*k +: 3]);
        c  = (int'(s) < NP);
        p  = c ? (m_s2[s[5:0]] ^ v) : 1'b0;
        cf = {s, e, v, 3'(n)};
        ch = (cf != m_pcfg[k]);
        l  = (n == 0) ? p : m_acc[k];
        nirq[k] = c && (e ? (!ch && l && !m_hist[k]) : l);
        m_hist[k] = ch ? p : l;
        if (ch || n == 0) begin m_acc[k] = p; m_cnt[k] = 0; end
        else if (p == m_acc[k]) m_cnt[k] = 0;
        else if (m_cnt[k] + 1 >= 4 * n) begin m_acc[k] = p; m_cnt[k] = 0; end
        else m_cnt[k]++;
        m_pcfg[k] = cf;
      end
      m_irq = nirq;
      m_rd  = m_reg[addr];
      if (wr_en) m_reg[addr] = (addr == 2'd3) ? (wdata & 32'h7777_7777) : wdata;
      m_s2 = m_s1;
      m_s1 = gpio;
    end
  end

  // per-clock comparison and pulse bookkeeping, away from the active edge
  int       pcnt [8], hcnt [8];
  logic [7:0] prev_irq = '0;
  always @(negedge clk) begin
    if (!rst) begin
      check(req, {24'h0, irq}, {24'h0, m_irq});
      check(req, rdata, m_rd);
    end
    for (int k = 0; k < 8; k++) begin
      if (irq[k] && !prev_irq[k]) pcnt[k]++;
      if (irq[k]) hcnt[k]++;
    end
    prev_irq = irq;
  end

  task automatic clr_counts();
    for (int k = 0; k < 8; k++) begin pcnt[k] = 0; hcnt[k] = 0; end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rdchk(string r, logic [1:0] a, logic [31:0] exp);
    @(negedge clk); #1;
    addr = a;
    @(negedge clk);
    check(r, rdata, exp);
  endtask

  task automatic setpin(int i, bit v);
    @(negedge clk); #1;
    gpio[i] = v;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=less", cyc);
      finish_run();
    end
  end

  initial begin
    clr_counts();
    repeat (5) @(negedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    req = "R1";
    @(negedge clk);
    check("R1", {24'h0, irq}, 32'h0);
    rdchk("R1", 2'd0, 32'h0000_0000);
    rdchk("R1", 2'd1, 32'hffff_ffff);
    rdchk("R1", 2'd2, 32'hffff_ffff);
    rdchk("R1", 2'd3, 32'h0000_0000);

    // R2: write and read back, spare filter bits dropped
    req = "R2";
    wr(2'd3, 32'hffff_ffff);
    rdchk("R2", 2'd3, 32'h7777_7777);
    wr(2'd0, 32'h00a5_005a);
    rdchk("R2", 2'd0, 32'h00a5_005a);
    wr(2'd0, 32'h0); wr(2'd3, 32'h0);

    // R3, R4: channel 2 selects pin 10 through byte 2 of word 1
    req = "R3";
    wr(2'd1, 32'hff0a_ffff);
    setpin(10, 1'b1); idle(6);
    check("R3", {24'h0, irq}, 32'h04);
    req = "R4";
    wr(2'd0, 32'h0004_0000); idle(6);
    check("R4", {24'h0, irq}, 32'h00);
    setpin(10, 1'b0); idle(6);
    check("R4", {24'h0, irq}, 32'h04);
    wr(2'd0, 32'h0); wr(2'd1, 32'hffff_ffff); idle(6);

    // R5: channel 5 on pin 7, rising then falling
    req = "R5";
    wr(2'd2, 32'hffff_07ff);
    wr(2'd0, 32'h0000_0020); idle(6); clr_counts();
    for (int i = 0; i < 3; i++) begin setpin(7, 1'b1); idle(8); setpin(7, 1'b0); idle(8); end
    idle(6);
    check("R5", pcnt[5], 3); check("R5", hcnt[5], 3);
    wr(2'd0, 32'h0020_0020); idle(6); clr_counts();
    for (int i = 0; i < 3; i++) begin setpin(7, 1'b1); idle(8); setpin(7, 1'b0); idle(8); end
    idle(6);
    check("R5", pcnt[5], 3); check("R5", hcnt[5], 3);
    wr(2'd0, 32'h0); wr(2'd2, 32'hffff_ffff); idle(6);

    // R6: both edges of pin 20 via channels 0 (falling) and 1 (rising)
    req = "R6";
    wr(2'd1, 32'hffff_1414);
    wr(2'd0, 32'h0001_0003); idle(6); clr_counts();
    for (int i = 0; i < 2; i++) begin setpin(20, 1'b1); idle(8); setpin(20, 1'b0); idle(8); end
    idle(6);
    check("R6", pcnt[0], 2); check("R6", pcnt[1], 2);
    wr(2'd1, 32'hffff_ffff); wr(2'd0, 32'h0); idle(6);

    // R7: out-of-range and 0xff selectors stay quiet
    req = "R7";
    wr(2'd2, 32'hffff_ff40);
    @(negedge clk); #1 gpio = '1;
    idle(6); clr_counts(); idle(10);
    check("R7", hcnt[4], 0);
    wr(2'd2, 32'hffff_ffff); idle(6);
    check("R7", {24'h0, irq}, 32'h0);
    wr(2'd2, 32'hffff_ff3f); idle(6);
    check("R7", {24'h0, irq}, 32'h10);
    @(negedge clk); #1 gpio = '0;
    wr(2'd2, 32'hffff_ffff); idle(6);

    // R8: channel 6 on pin 30 with a 4-clock filter window
    req = "R8";
    wr(2'd2, 32'hff1e_ffff);
    wr(2'd3, 32'h0100_0000); idle(10); clr_counts();
    setpin(30, 1'b1); idle(2); setpin(30, 1'b0); idle(10);
    check("R8", hcnt[6], 0);
    setpin(30, 1'b1); idle(6);
    check("R8", {31'h0, irq[6]}, 32'h0);
    idle(1);
    check("R8", {31'h0, irq[6]}, 32'h1);
    setpin(30, 1'b0); wr(2'd3, 32'h0); wr(2'd2, 32'hffff_ffff); idle(10);

    // R9: reconfiguration onto a high pin yields no pulse
    req = "R9";
    setpin(40, 1'b1);
    wr(2'd2, 32'h29ff_ffff);
    wr(2'd0, 32'h0000_0080); idle(6); clr_counts();
    wr(2'd2, 32'h28ff_ffff); idle(6);
    check("R9", pcnt[7], 0);
    wr(2'd0, 32'h0); idle(6);
    check("R9", {31'h0, irq[7]}, 32'h1);
    clr_counts(); wr(2'd0, 32'h0000_0080); idle(6);
    check("R9", pcnt[7], 0);
    setpin(40, 1'b0); idle(8); setpin(40, 1'b1); idle(6);
    check("R9", pcnt[7], 1);
    wr(2'd0, 32'h0); wr(2'd2, 32'hffff_ffff);
    @(negedge clk); #1 gpio = '0; idle(6);

    // random mix against the model
    req = "R4";
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      @(negedge clk); #1;
      gpio  = gpio ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      wr_en = ($urandom % 24 == 0);
      addr  = 2'($urandom % 4);
      d = $urandom;
      if (addr == 2'd1 || addr == 2'd2)
        for (int b = 0; b < 4; b++)
          d[8*b +: 8] = ($urandom % 5 == 0) ? 8'hff : 8'($urandom % 72);
      if (addr == 2'd3) d = d & 32'h1111_1111;
      wdata = d;
    end
    @(negedge clk); #1 wr_en = 1'b0;
    idle(10);

    finish_run();
  end
endmodule